// File: doc/BRIEF.md
# Paged Data Address Translator with Byte Store

This block turns the 8-bit data address carried by an instruction or a memory pointer into a 16-bit physical data address. Addresses whose top bit is set form a shared upper page. That page is never paged, so it maps straight into the first 256 bytes. Addresses whose top bit is clear are offsets into one of 256 windows of 128 bytes. The window is chosen by an 8-bit page register. The page register itself is visible at the top address of the upper page. Accesses made on behalf of the stack skip the page register and always use window 0.

Next to the translation, the block decides what backs each physical address. It may be general RAM, a byte of the sixteen-entry register file, or nothing. It also holds the byte store for every populated location. Windows 0, 1 and 2 are populated (384 bytes). Window 0 has no RAM in its last sixteen offsets. Above window 2 nothing is populated. A flag reports when the page register points past the populated windows. One access is accepted per cycle, and its response appears one cycle later.

Top module: `dmem_seg_extender`

## Requirements
- R1: An access with address bit 7 set has physical address 0x00 followed by the 8-bit address, whatever the page register holds.
- R2: A non-stack access with address bit 7 clear has physical address {page, 0, address[6:0]}, so it lands in the range page*256 + 0x00 to page*256 + 0x7F.
- R3: A stack access (acc_stack=1) with address bit 7 clear uses page 0. A stack write to 0xFF leaves the page register unchanged.
- R4: The page register is 0 after reset. A non-stack write to 0xFF loads it at that clock edge, and the new value steers every later access.
- R5: A read of 0xFF returns the page register value held when the read was accepted.
- R6: Exactly one of hit_ram, hit_regs, hit_hole is 1 on each response, and all three are 0 otherwise. hit_ram covers 0x0000–0x006F and 0x0100–0x017F and 0x0200–0x027F. hit_regs covers 0x00F0–0x00FF. hit_hole covers 0x0070–0x007F, 0x0080–0x00EF and every window above 2.
- R7: A read of a hole returns 0xFF. A write to a hole changes no stored byte. In particular, offset 0x75 in window 0 does not alias register byte 0xF5.
- R8: A read of a RAM or register-file location returns the byte last written there. Windows 1 and 2 and the base window are separate storage.
- R9: seg_oob is 1 exactly when the page register is above 2. It changes in the same cycle as seg_value.
- R10: rsp_valid is 1 in the cycle after an accepted access (acc_valid=1) and 0 otherwise. phys_addr, rd_data and the hit flags belong to that response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Access accepted this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_stack | input | 1 | Access made through the stack pointer |
| acc_addr | input | 8 | 8-bit data address |
| acc_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | Response for the access of the previous cycle |
| rd_data | output | 8 | Read byte |
| phys_addr | output | 16 | Translated physical address |
| hit_ram | output | 1 | Response address is general RAM |
| hit_regs | output | 1 | Response address is in the register file |
| hit_hole | output | 1 | Response address is unpopulated |
| seg_value | output | 8 | Current page register |
| seg_oob | output | 1 | Page register points past populated windows |

## Verification
The properties assume that acc_valid is low while reset is asserted. They also assume that acc_addr, acc_stack, acc_write and acc_wdata are stable across the edge that accepts an access, because the translation checks compare the response with the sampled request. The bench drives every input on the falling edge and holds acc_valid low during and right after reset. It reads only locations it has written earlier, or holes, so no expected byte depends on power-up RAM contents.

// File: rtl/dmx_pkg.sv
package dmx_pkg;

  typedef enum logic [1:0] {
    RGN_RAM  = 2'd0,
    RGN_REGS = 2'd1,
    RGN_HOLE = 2'd2
  } rgn_e;

endpackage

// File: rtl/seg_addr_map.sv
module seg_addr_map
  import dmx_pkg::*;
#(
  parameter int ADDR_W       = 8,
  parameter int SEG_W        = 8,
  parameter int MAX_SEG      = 2,
  parameter int BASE_RAM_END = 112,
  parameter int REGS_BASE    = 240,
  parameter int IDX_W        = 9
) (
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    stack,
  input  logic [SEG_W-1:0]        seg,
  output logic [SEG_W+ADDR_W-1:0] phys,
  output rgn_e                    rgn,
  output logic [IDX_W-1:0]        idx,
  output logic                    seg_loc
);

  localparam int OFF_W   = ADDR_W - 1;
  localparam int SEG_LOC = (2 ** ADDR_W) - 1;

  logic [SEG_W-1:0] eff_seg;

  always_comb begin
    eff_seg = stack ? '0 : seg;
    phys    = '0;
    rgn     = RGN_HOLE;
    idx     = '0;
    seg_loc = (addr == ADDR_W'(SEG_LOC));
    if (addr[ADDR_W-1]) begin
      // shared upper page: never extended
      phys = {{SEG_W{1'b0}}, addr};
      if (addr >= ADDR_W'(REGS_BASE)) begin
        rgn = RGN_REGS;
        idx = IDX_W'(BASE_RAM_END) + IDX_W'(addr - ADDR_W'(REGS_BASE));
      end
    end else begin
      // lower half: offset inside the selected window
      phys = {eff_seg, addr};
      if (eff_seg == '0) begin
        if (addr < ADDR_W'(BASE_RAM_END)) begin
          rgn = RGN_RAM;
          idx = IDX_W'(addr);
        end
      end else if (int'(eff_seg) <= MAX_SEG) begin
        rgn = RGN_RAM;
        idx = IDX_W'({eff_seg, addr[OFF_W-1:0]});
      end
    end
  end

endmodule

// File: rtl/seg_pager_reg.sv
module seg_pager_reg #(
  parameter int SEG_W   = 8,
  parameter int MAX_SEG = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [SEG_W-1:0] wr_data,
  output logic [SEG_W-1:0] seg_q,
  output logic             oob_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      seg_q <= '0;
      oob_q <= 1'b0;
    end else if (wr_en) begin
      seg_q <= wr_data;
      oob_q <= (int'(wr_data) > MAX_SEG);
    end
  end

  // R4: a load takes effect on the edge it is presented
  p_seg_load_r4: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> seg_q == $past(wr_data));

  // R9: flag only moves together with the register
  p_oob_moves_with_seg_r9: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(oob_q) && $stable(seg_q));

endmodule

// File: rtl/seg_ram_bank.sv
module seg_ram_bank #(
  parameter int DEPTH  = 384,
  parameter int IDX_W  = 9,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic              re,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[idx] <= wdata;
    if (re) rdata <= mem[idx];
  end

endmodule

// File: rtl/dmem_seg_extender.sv
module dmem_seg_extender
  import dmx_pkg::*;
#(
  parameter int ADDR_W       = 8,
  parameter int SEG_W        = 8,
  parameter int DATA_W       = 8,
  parameter int MAX_SEG      = 2,
  parameter int BASE_RAM_END = 112,
  parameter int REGS_BASE    = 240
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    acc_valid,
  input  logic                    acc_write,
  input  logic                    acc_stack,
  input  logic [ADDR_W-1:0]       acc_addr,
  input  logic [DATA_W-1:0]       acc_wdata,
  output logic                    rsp_valid,
  output logic [DATA_W-1:0]       rd_data,
  output logic [SEG_W+ADDR_W-1:0] phys_addr,
  output logic                    hit_ram,
  output logic                    hit_regs,
  output logic                    hit_hole,
  output logic [SEG_W-1:0]        seg_value,
  output logic                    seg_oob
);

  localparam int OFF_W     = ADDR_W - 1;
  localparam int PHYS_W    = SEG_W + ADDR_W;
  localparam int RAM_DEPTH = (MAX_SEG + 1) * (2 ** OFF_W);
  localparam int IDX_W     = $clog2(RAM_DEPTH);

  logic [PHYS_W-1:0] map_phys;
  rgn_e              map_rgn;
  logic [IDX_W-1:0]  map_idx;
  logic              map_seg_loc;
  logic [DATA_W-1:0] ram_rdata;
  logic              ram_we;
  logic              ram_re;
  logic              seg_we;

  logic              rsp_valid_q;
  logic [PHYS_W-1:0] phys_q;
  rgn_e              rgn_q;
  logic              segloc_q;
  logic [SEG_W-1:0]  seg_snap_q;

  seg_addr_map #(
    .ADDR_W(ADDR_W), .SEG_W(SEG_W), .MAX_SEG(MAX_SEG),
    .BASE_RAM_END(BASE_RAM_END), .REGS_BASE(REGS_BASE), .IDX_W(IDX_W)
  ) map_i (
    .addr(acc_addr), .stack(acc_stack), .seg(seg_value),
    .phys(map_phys), .rgn(map_rgn), .idx(map_idx), .seg_loc(map_seg_loc)
  );

  assign ram_we = acc_valid && acc_write && (map_rgn != RGN_HOLE) && !map_seg_loc;
  assign ram_re = acc_valid && !acc_write && (map_rgn != RGN_HOLE);
  assign seg_we = acc_valid && acc_write && map_seg_loc && !acc_stack;

  seg_pager_reg #(.SEG_W(SEG_W), .MAX_SEG(MAX_SEG)) seg_i (
    .clk(clk), .rst(rst), .wr_en(seg_we), .wr_data(SEG_W'(acc_wdata)),
    .seg_q(seg_value), .oob_q(seg_oob)
  );

  seg_ram_bank #(.DEPTH(RAM_DEPTH), .IDX_W(IDX_W), .DATA_W(DATA_W)) ram_i (
    .clk(clk), .we(ram_we), .re(ram_re), .idx(map_idx),
    .wdata(acc_wdata), .rdata(ram_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid_q <= 1'b0;
      phys_q      <= '0;
      rgn_q       <= RGN_HOLE;
      segloc_q    <= 1'b0;
      seg_snap_q  <= '0;
    end else begin
      rsp_valid_q <= acc_valid;
      if (acc_valid) begin
        phys_q     <= map_phys;
        rgn_q      <= map_rgn;
        segloc_q   <= map_seg_loc;
        seg_snap_q <= seg_value;
      end
    end
  end

  always_comb begin
    if (rgn_q == RGN_HOLE)  rd_data = '1;
    else if (segloc_q)      rd_data = DATA_W'(seg_snap_q);
    else                    rd_data = ram_rdata;
  end

  assign rsp_valid = rsp_valid_q;
  assign phys_addr = phys_q;
  assign hit_ram   = rsp_valid_q && (rgn_q == RGN_RAM);
  assign hit_regs  = rsp_valid_q && (rgn_q == RGN_REGS);
  assign hit_hole  = rsp_valid_q && (rgn_q == RGN_HOLE);

  // R10: one response per accepted access, one cycle later
  p_rsp_follows_r10: assert property (@(posedge clk) disable iff (rst)
    acc_valid |=> rsp_valid);
  p_rsp_idle_r10: assert property (@(posedge clk) disable iff (rst)
    !acc_valid |=> !rsp_valid);

  // R1: upper page passes straight through
  p_upper_phys_r1: assert property (@(posedge clk) disable iff (rst)
    acc_valid && acc_addr[ADDR_W-1] |=> phys_addr == {{SEG_W{1'b0}}, $past(acc_addr)});

  // R2: lower half takes the page register
  p_lower_phys_r2: assert property (@(posedge clk) disable iff (rst)
    acc_valid && !acc_addr[ADDR_W-1] && !acc_stack
      |=> phys_addr == {$past(seg_value), $past(acc_addr)});

  // R3: stack accesses pinned to window 0 and never touch the page register
  p_stack_seg0_r3: assert property (@(posedge clk) disable iff (rst)
    acc_valid && !acc_addr[ADDR_W-1] && acc_stack |=> phys_addr[PHYS_W-1:ADDR_W] == '0);
  p_stack_keeps_seg_r3: assert property (@(posedge clk) disable iff (rst)
    acc_valid && acc_stack |=> $stable(seg_value));

  // R6: exactly one region per response; windows past the last one are holes
  p_flags_onehot_r6: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $countones({hit_ram, hit_regs, hit_hole}) == 1);
  p_oob_is_hole_r6: assert property (@(posedge clk) disable iff (rst)
    acc_valid && !acc_addr[ADDR_W-1] && !acc_stack && seg_oob |=> hit_hole);

  // R9: loading a value past the last window raises the flag
  p_oob_on_load_r9: assert property (@(posedge clk) disable iff (rst)
    acc_valid && acc_write && !acc_stack && (acc_addr == '1)
      && (int'(acc_wdata) > MAX_SEG) |=> seg_oob);

endmodule

// File: tb/dmem_seg_extender_tb_top.sv
module dmem_seg_extender_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 38;

  // {wr, stack, addr, wdata, exp_data, exp_phys, exp_rgn(0 ram,1 regs,2 hole), exp_oob}
  localparam logic [44:0] VEC [NV] = '{
    {1'b1,1'b0,8'h10,8'hA1,8'h00,16'h0010,2'd0,1'b0},
    {1'b1,1'b0,8'hF3,8'h5C,8'h00,16'h00F3,2'd1,1'b0},
    {1'b1,1'b0,8'hF5,8'h3E,8'h00,16'h00F5,2'd1,1'b0},
    {1'b0,1'b0,8'h10,8'h00,8'hA1,16'h0010,2'd0,1'b0},
    {1'b0,1'b0,8'hF3,8'h00,8'h5C,16'h00F3,2'd1,1'b0},
    {1'b1,1'b0,8'hFF,8'h01,8'h00,16'h00FF,2'd1,1'b0},
    {1'b0,1'b0,8'hFF,8'h00,8'h01,16'h00FF,2'd1,1'b0},
    {1'b1,1'b0,8'h10,8'hB2,8'h00,16'h0110,2'd0,1'b0},
    {1'b0,1'b0,8'h10,8'h00,8'hB2,16'h0110,2'd0,1'b0},
    {1'b0,1'b1,8'h10,8'h00,8'hA1,16'h0010,2'd0,1'b0},
    {1'b1,1'b0,8'h7F,8'hC3,8'h00,16'h017F,2'd0,1'b0},
    {1'b1,1'b0,8'hFF,8'h02,8'h00,16'h00FF,2'd1,1'b0},
    {1'b1,1'b0,8'h10,8'hD4,8'h00,16'h0210,2'd0,1'b0},
    {1'b0,1'b0,8'h10,8'h00,8'hD4,16'h0210,2'd0,1'b0},
    {1'b0,1'b0,8'hF3,8'h00,8'h5C,16'h00F3,2'd1,1'b0},
    {1'b1,1'b0,8'hFF,8'h01,8'h00,16'h00FF,2'd1,1'b0},
    {1'b0,1'b0,8'h7F,8'h00,8'hC3,16'h017F,2'd0,1'b0},
    {1'b0,1'b0,8'h10,8'h00,8'hB2,16'h0110,2'd0,1'b0},
    {1'b1,1'b0,8'hFF,8'h00,8'h00,16'h00FF,2'd1,1'b0},
    {1'b1,1'b0,8'h75,8'h99,8'h00,16'h0075,2'd2,1'b0},
    {1'b0,1'b0,8'hF5,8'h00,8'h3E,16'h00F5,2'd1,1'b0},
    {1'b0,1'b0,8'h75,8'h00,8'hFF,16'h0075,2'd2,1'b0},
    {1'b1,1'b0,8'h90,8'h12,8'h00,16'h0090,2'd2,1'b0},
    {1'b0,1'b0,8'h90,8'h00,8'hFF,16'h0090,2'd2,1'b0},
    {1'b1,1'b1,8'hFF,8'h07,8'h00,16'h00FF,2'd1,1'b0},
    {1'b0,1'b0,8'hFF,8'h00,8'h00,16'h00FF,2'd1,1'b0},
    {1'b1,1'b0,8'hFF,8'h03,8'h00,16'h00FF,2'd1,1'b1},
    {1'b0,1'b0,8'h10,8'h00,8'hFF,16'h0310,2'd2,1'b1},
    {1'b1,1'b0,8'h10,8'hEE,8'h00,16'h0310,2'd2,1'b1},
    {1'b0,1'b1,8'h10,8'h00,8'hA1,16'h0010,2'd0,1'b1},
    {1'b0,1'b1,8'h70,8'h00,8'hFF,16'h0070,2'd2,1'b1},
    {1'b0,1'b0,8'hF3,8'h00,8'h5C,16'h00F3,2'd1,1'b1},
    {1'b1,1'b0,8'hFF,8'h00,8'h00,16'h00FF,2'd1,1'b0},
    {1'b0,1'b0,8'h10,8'h00,8'hA1,16'h0010,2'd0,1'b0},
    {1'b1,1'b0,8'h6F,8'h4D,8'h00,16'h006F,2'd0,1'b0},
    {1'b0,1'b0,8'h6F,8'h00,8'h4D,16'h006F,2'd0,1'b0},
    {1'b0,1'b0,8'h70,8'h00,8'hFF,16'h0070,2'd2,1'b0},
    {1'b1,1'b0,8'hFF,8'h02,8'h00,16'h00FF,2'd1,1'b0}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        acc_valid = 1'b0;
  logic        acc_write = 1'b0;
  logic        acc_stack = 1'b0;
  logic [7:0]  acc_addr = '0;
  logic [7:0]  acc_wdata = '0;
  logic        rsp_valid;
  logic [7:0]  rd_data;
  logic [15:0] phys_addr;
  logic        hit_ram, hit_regs, hit_hole;
  logic [7:0]  seg_value;
  logic        seg_oob;

  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dmem_seg_extender dut_i (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_stack(acc_stack), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
    .rsp_valid(rsp_valid), .rd_data(rd_data), .phys_addr(phys_addr),
    .hit_ram(hit_ram), .hit_regs(hit_regs), .hit_hole(hit_hole),
    .seg_value(seg_value), .seg_oob(seg_oob)
  );

  task automatic check(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // called at a falling edge; returns at the falling edge where the response is visible
  task automatic access(input logic wr, input logic stk,
                        input logic [7:0] a, input logic [7:0] d);
    acc_valid = 1'b1; acc_write = wr; acc_stack = stk; acc_addr = a; acc_wdata = d;
    @(negedge clk);
    acc_valid = 1'b0; acc_write = 1'b0; acc_stack = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R10 watchdog: actual=running expected=finished");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // reset state: R4, R9, R10, R6
    check("R4", "seg after reset", 16'(seg_value), 16'h0000);
    check("R9", "oob after reset", 16'(seg_oob), 16'h0000);
    check("R10", "rsp_valid idle", 16'(rsp_valid), 16'h0000);
    check("R6", "flags idle", 16'({hit_ram, hit_regs, hit_hole}), 16'h0000);

    for (int i = 0; i < NV; i++) begin
      logic [44:0] v;
      logic [2:0]  exp_flags;
      string       ptag;
      string       dtag;
      v = VEC[i];
      access(v[44], v[43], v[42:35], v[34:27]);
      exp_flags = (v[2:1] == 2'd0) ? 3'b100 : (v[2:1] == 2'd1) ? 3'b010 : 3'b001;
      ptag = v[42] ? "R1" : (v[43] ? "R3" : "R2");
      check("R10", $sformatf("rsp_valid vec %0d", i), 16'(rsp_valid), 16'h0001);
      check(ptag, $sformatf("phys vec %0d", i), phys_addr, v[18:3]);
      check("R6", $sformatf("region vec %0d", i), 16'({hit_ram, hit_regs, hit_hole}), 16'(exp_flags));
      check("R9", $sformatf("oob vec %0d", i), 16'(seg_oob), 16'(v[0]));
      if (!v[44]) begin
        // R8 covers window separation (R11 of the design intent) through vectors 16/17/33
        dtag = (v[2:1] == 2'd2) ? "R7" : ((v[42:35] == 8'hFF) ? "R5" : "R8");
        check(dtag, $sformatf("rd_data vec %0d", i), 16'(rd_data), 16'(v[26:19]));
      end
    end

    // R4: the page loaded by the last vector (2) is visible at the port
    check("R4", "seg loaded", 16'(seg_value), 16'h0002);
    // R10: idle cycle after a response
    @(negedge clk);
    check("R10", "rsp_valid drops", 16'(rsp_valid), 16'h0000);
    // R4: mid-run reset clears the page
    access(1'b1, 1'b0, 8'hFF, 8'h05);
    check("R9", "oob at 5", 16'(seg_oob), 16'h0001);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R4", "seg after mid reset", 16'(seg_value), 16'h0000);
    check("R9", "oob after mid reset", 16'(seg_oob), 16'h0000);
    // R3: stack write to FF after reset still leaves page at 0
    access(1'b1, 1'b1, 8'hFF, 8'h01);
    check("R3", "stack write FF ignored", 16'(seg_value), 16'h0000);
    // R8: RAM survives reset
    access(1'b0, 1'b0, 8'h6F, 8'h00);
    check("R8", "ram kept over reset", 16'(rd_data), 16'h004D);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule